// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This block timestamps events seen on an asynchronous input pin. The pin is brought into the clock domain through a chain of synchronizer flops. A registered copy of the synchronized level gives the rising and falling edges. When an edge of the selected kind occurs, the block copies the value of an external free-running timebase into a capture register. In the cycle after that, it raises a one-cycle strobe and sets a sticky event flag. The flag stays set until the clear input is pulsed.

A 2-bit type input selects the trigger:

- `00` fires on any edge.
- `01` fires on rising edges only.
- `10` fires on falling edges only.
- `11` fires once per complete pulse, on the second edge of each pair.

A small trigger state machine tracks the enable and the edge parity. Its states are `ST_OFF` (disabled), `ST_WAIT` (no half pulse pending) and `ST_HALF` (first edge of a pulse seen, pulse mode only). Its transitions are:

- `T_ENABLE`: `ST_OFF` to `ST_WAIT` when the enable goes high.
- `T_DISABLE`: any state to `ST_OFF` when the enable is low.
- `T_RETYPE`: any enabled state to `ST_WAIT` when the type changes.
- `T_OPEN`: `ST_WAIT` to `ST_HALF` on an edge in pulse mode.
- `T_CLOSE`: `ST_HALF` to `ST_WAIT` on an edge. This transition fires a capture.

In the other modes, a matching edge fires a capture and the machine stays in `ST_WAIT`.

Top module: `icap_unit`

## Requirements
- R1: After reset, `cap_o` is 0, `flag_o` is 0 and `strobe_o` is 0.
- R2: With `type_i` = 00, every change of the pin level, in either direction, produces a capture.
- R3: With `type_i` = 01, only a 0-to-1 change of the pin produces a capture; a 1-to-0 change produces none.
- R4: With `type_i` = 10, only a 1-to-0 change of the pin produces a capture; a 0-to-1 change produces none.
- R5: With `type_i` = 11, edges are counted in pairs, and only the second edge of each pair produces a capture. The pair count restarts when the block is enabled and when `type_i` changes. An edge arriving in the same cycle as a type change is discarded.
- R6: Suppose a pin change is set up before clock edge k and the pin is then held. If it triggers a capture, then after clock edge k+2 `cap_o` equals the value `time_i` had at edge k+2, and `strobe_o` is high.
- R7: `strobe_o` is high for exactly one cycle per capture. `cap_o` keeps its value when no capture occurs.
- R8: `flag_o` sets on a capture and stays set until `clr_i` is sampled high. If a capture and a clear meet on the same edge, the flag stays set.
- R9: While `en_i` is low, pin changes cause no capture. A level that changed while the block was disabled produces no capture after re-enabling. The first edge after re-enabling is captured normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous event pin |
| time_i | input | TW | Timebase value to be latched |
| en_i | input | 1 | Capture enable |
| type_i | input | 2 | Trigger type: 00 any, 01 rise, 10 fall, 11 pulse |
| clr_i | input | 1 | Clears the sticky event flag |
| cap_o | output | TW | Captured timestamp |
| flag_o | output | 1 | Sticky event flag |
| strobe_o | output | 1 | One-cycle capture strobe |

## Verification
The hardest conditions to reach are the pulse-mode parity being restarted mid-pulse and a clear that lands on the exact edge where a capture fires. For the first, the vector table switches into pulse mode while the pin already sits high, so the following falling edge must be treated as an opening edge and not as a closing one. For the second, a directed test raises `clr_i` during the cycle in which the synchronized edge is visible. That timing is counted from the moment the pin is driven through both synchronizer stages.

// File: rtl/icap_pkg.sv
package icap_pkg;
    typedef enum logic [1:0] {
        TRIG_ANY   = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_PULSE = 2'b11
    } trig_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'b00,
        ST_WAIT = 2'b01,
        ST_HALF = 2'b10
    } trig_state_e;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[0] <= 1'b0;
                    else         chain_q[0] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= 1'b0;
                    else         chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // The previous level follows the pin at all times, enabled or not.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= chain_q[STAGES-1];
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o =  chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] &  prev_q;
endmodule

// File: rtl/icap_trig_fsm.sv
module icap_trig_fsm
    import icap_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        en_i,
    input  trig_e       type_i,
    input  logic        rise_i,
    input  logic        fall_i,
    output trig_state_e state_o,
    output logic        fire_o
);
    trig_state_e state_q, state_d;
    trig_e       type_q;
    logic        retype;
    logic        any_edge;

    assign retype   = (type_i != type_q);
    assign any_edge = rise_i | fall_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            type_q  <= TRIG_ANY;
        end else begin
            state_q <= state_d;
            type_q  <= type_i;
        end
    end

    always_comb begin
        state_d = state_q;
        fire_o  = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) state_d = ST_WAIT;                 // T_ENABLE
            end
            ST_WAIT: begin
                if (!en_i)       state_d = ST_OFF;           // T_DISABLE
                else if (retype) state_d = ST_WAIT;          // T_RETYPE
                else begin
                    unique case (type_i)
                        TRIG_ANY:   fire_o = any_edge;
                        TRIG_RISE:  fire_o = rise_i;
                        TRIG_FALL:  fire_o = fall_i;
                        TRIG_PULSE: if (any_edge) state_d = ST_HALF; // T_OPEN
                        default:    fire_o = 1'b0;
                    endcase
                end
            end
            ST_HALF: begin
                if (!en_i)         state_d = ST_OFF;         // T_DISABLE
                else if (retype)   state_d = ST_WAIT;        // T_RETYPE
                else if (any_edge) begin
                    state_d = ST_WAIT;                       // T_CLOSE
                    fire_o  = 1'b1;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/icap_store.sv
module icap_store #(
    parameter int TW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fire_i,
    input  logic [TW-1:0] time_i,
    input  logic          clr_i,
    output logic [TW-1:0] cap_o,
    output logic          flag_o,
    output logic          strobe_o
);
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cap_o    <= '0;
            flag_o   <= 1'b0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= fire_i;
            if (fire_i)     cap_o  <= time_i;
            if (fire_i)     flag_o <= 1'b1;   // capture wins over clear
            else if (clr_i) flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int TW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pin_i,
    input  logic [TW-1:0] time_i,
    input  logic          en_i,
    input  logic [1:0]    type_i,
    input  logic          clr_i,
    output logic [TW-1:0] cap_o,
    output logic          flag_o,
    output logic          strobe_o
);
    logic        lvl_s;
    logic        rise_s;
    logic        fall_s;
    logic        fire;
    trig_state_e fsm_state;
    trig_e       trig;

    assign trig = trig_e'(type_i);

    icap_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .lvl_o  (lvl_s),
        .rise_o (rise_s),
        .fall_o (fall_s)
    );

    icap_trig_fsm fsm_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .type_i  (trig),
        .rise_i  (rise_s),
        .fall_i  (fall_s),
        .state_o (fsm_state),
        .fire_o  (fire)
    );

    icap_store #(.TW(TW)) store_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fire_i   (fire),
        .time_i   (time_i),
        .clr_i    (clr_i),
        .cap_o    (cap_o),
        .flag_o   (flag_o),
        .strobe_o (strobe_o)
    );
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk
    import icap_pkg::*;
#(
    parameter int TW = 32
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [1:0]    type_i,
    input logic          clr_i,
    input logic          lvl_s,
    input trig_state_e   fsm_state,
    input logic [TW-1:0] cap_o,
    input logic          flag_o,
    input logic          strobe_o
);
    p_rise_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_o && $past(type_i) == 2'b01) |-> $past(lvl_s) == 1'b1);

    p_fall_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_o && $past(type_i) == 2'b10) |-> $past(lvl_s) == 1'b0);

    p_pulse_closes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (strobe_o && $past(type_i) == 2'b11) |-> $past(fsm_state) == ST_HALF);

    p_cap_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_o |-> $stable(cap_o));

    p_strobe_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        strobe_o |-> flag_o);

    p_clear_drops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (strobe_o || !flag_o));

    p_off_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsm_state == ST_OFF |=> !strobe_o);
endmodule

bind icap_unit icap_unit_chk #(.TW(TW)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .type_i    (type_i),
    .clr_i     (clr_i),
    .lvl_s     (lvl_s),
    .fsm_state (fsm_state),
    .cap_o     (cap_o),
    .flag_o    (flag_o),
    .strobe_o  (strobe_o)
);

// File: tb/icap_unit_tb.sv
module icap_unit_tb_top;
    localparam int TW = 32;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pin = 1'b0;
    logic [TW-1:0] tstamp = '0;
    logic          en = 1'b0;
    logic [1:0]    ttype = 2'b00;
    logic          clr = 1'b0;
    logic [TW-1:0] cap;
    logic          flag;
    logic          strobe;

    int checks = 0;
    int fails  = 0;
    logic [TW-1:0] last_cap = '0;

    always #5 clk = ~clk;

    icap_unit #(.TW(TW)) dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .pin_i    (pin),
        .time_i   (tstamp),
        .en_i     (en),
        .type_i   (ttype),
        .clr_i    (clr),
        .cap_o    (cap),
        .flag_o   (flag),
        .strobe_o (strobe)
    );

    // Vector fields: type, new pin level, timestamp, capture expected.
    localparam logic [1:0] V_TYPE [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b10, 2'b10,
                                           2'b11, 2'b11, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11};
    localparam logic       V_PIN  [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                           1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic       V_FIRE [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1,
                                           1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive the pin, then sample the cycle after the third clock edge.
    task automatic edge_and_check(input logic lvl, input logic [TW-1:0] ts,
                                  input logic exp_fire, input string req);
        @(negedge clk);
        pin    = lvl;
        tstamp = ts;
        cycles(3);
        check(strobe == exp_fire, req, "strobe", strobe, exp_fire);
        if (exp_fire) last_cap = ts;
        check(cap == last_cap, req, "cap", cap, last_cap);
        check(flag == exp_fire, req, "flag", flag, exp_fire);
        @(negedge clk);
        check(strobe == 1'b0, "R7", "strobe width", strobe, 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    bit done = 1'b0;
    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        cycles(3);
        check(cap == 0,    "R1", "reset cap",    cap,    0);
        check(flag == 0,   "R1", "reset flag",   flag,   0);
        check(strobe == 0, "R1", "reset strobe", strobe, 0);
        rst_n = 1'b1;
        cycles(2);
        en = 1'b1;
        cycles(3);

        // Vector table: R2 any, R3 rise, R4 fall, R5 pulse pairs and retype, R6 stamp.
        for (int v = 0; v < NV; v++) begin
            if (ttype != V_TYPE[v]) begin
                ttype = V_TYPE[v];
                cycles(2);
            end
            edge_and_check(V_PIN[v], TW'(100 + v), V_FIRE[v],
                           V_TYPE[v] == 2'b00 ? "R2" : V_TYPE[v] == 2'b01 ? "R3" :
                           V_TYPE[v] == 2'b10 ? "R4" : "R5");
        end

        // R8: clear arriving on the same edge as a capture loses.
        ttype = 2'b00;
        cycles(2);
        pin    = 1'b0;
        tstamp = 32'd500;
        cycles(2);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(strobe == 1'b1, "R8", "collision strobe", strobe, 1);
        check(flag == 1'b1,   "R8", "collision flag",   flag,   1);
        check(cap == 32'd500, "R6", "collision cap",    cap,    500);
        last_cap = 32'd500;
        cycles(3);
        check(flag == 1'b1, "R8", "flag sticky", flag, 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check(flag == 1'b0, "R8", "flag cleared", flag, 0);

        // R9: disabled, pin moves and stays changed.
        en = 1'b0;
        cycles(2);
        tstamp = 32'd600;
        pin = 1'b1;
        cycles(4);
        pin = 1'b0;
        cycles(4);
        pin = 1'b1;
        cycles(5);
        check(flag == 1'b0,   "R9", "disabled flag", flag, 0);
        check(cap == last_cap, "R9", "disabled cap",  cap,  last_cap);
        en = 1'b1;
        cycles(6);
        check(flag == 1'b0,   "R9", "re-enable no false edge", flag, 0);
        check(cap == last_cap, "R9", "re-enable cap",          cap,  last_cap);
        edge_and_check(1'b0, 32'd700, 1'b1, "R9");

        // R5: enable restarts pulse parity after a half pulse.
        ttype = 2'b11;
        cycles(2);
        edge_and_check(1'b1, 32'd800, 1'b0, "R5");
        en = 1'b0;
        cycles(3);
        en = 1'b1;
        cycles(3);
        edge_and_check(1'b0, 32'd801, 1'b0, "R5");
        edge_and_check(1'b1, 32'd802, 1'b1, "R5");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule